// File: doc/BRIEF.md
# CAN Bit Stuffing Codec

This block handles bit stuffing for a serial CAN bit stream, in both directions. The transmit path watches the bits an upstream framer hands it. After a run of equal bits of the configured length inside the stuffed part of the frame, it inserts one bit of the opposite level. That bit gives receivers an edge to resynchronize on. While the inserted bit occupies the line, the transmit path holds the upstream back for one bit slot.

The receive path runs the same count over the incoming line bits. It silently discards the complementary bit that follows a full run. If the bit in that position repeats the level of the run instead, it raises a one-cycle stuff error; a run of six low bits and a run of six high bits are both errors. Both paths are paced by a per-bit strobe supplied by an external bit-timing unit.

Each path has an enable that marks the stuffed region of the frame, from start of frame through the CRC sequence. A start-of-frame marker restarts the run count. Outside the region, bits pass through untouched.

Top module: `can_stuff_codec`

## Requirements
- R1: With `tx_en` high, after RUN_LEN (default 5) consecutive transmitted bits of one level, the next bit slot on `tx_bit_out` carries the opposite level, for runs of either polarity.
- R2: `tx_ready` is low for exactly one strobe slot, the slot in which a stuff bit is sent. `tx_bit_in` presented in that slot is not consumed; the same upstream bit goes out in the following slot.
- R3: An inserted stuff bit counts as the first bit of a new run. Another RUN_LEN-1 bits of its level then trigger the next insertion.
- R4: While `tx_en` is low, input bits appear on `tx_bit_out` unchanged and no stuff bit is inserted, however long the run.
- R5: With `rx_en` high, the bit after RUN_LEN equal received bits is removed when it has the opposite level: `rx_valid` stays low for that strobe.
- R6: With `rx_en` high, a bit of the same level following RUN_LEN equal received bits pulses `rx_stuff_err` for one cycle with `rx_valid` low. This applies to low (dominant) and high (recessive) runs alike.
- R7: On the receive side, a removed stuff bit starts a new run of its own level, and the run count restarts from zero after a stuff error.
- R8: While `rx_en` is low, every received bit is delivered with `rx_valid` high, and nothing is removed or flagged.
- R9: On each path, the run count clears whenever the enable is low and no stuff bit is pending. A strobe with the start-of-frame input high makes its bit the first of a new run.
- R10: After reset, `tx_ready` is 1, `tx_bit_out` is 1 (recessive), and `rx_valid` and `rx_stuff_err` are 0.
- R11: Each path's result for a strobe appears on its outputs in the clock cycle after that strobe. `rx_valid` and `rx_stuff_err` are low in every cycle that does not follow a receive strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_strobe | input | 1 | Transmit bit slot tick |
| tx_en | input | 1 | Transmit bit lies in the stuffed region |
| tx_sof | input | 1 | Transmit bit is the start of frame |
| tx_bit_in | input | 1 | Bit from the upstream framer |
| tx_ready | output | 1 | Upstream bit is consumed at this strobe |
| tx_bit_out | output | 1 | Bit driven toward the line |
| rx_strobe | input | 1 | Receive bit sample tick |
| rx_en | input | 1 | Received bit lies in the stuffed region |
| rx_sof | input | 1 | Received bit is the start of frame |
| rx_bit_in | input | 1 | Sampled line bit |
| rx_bit_out | output | 1 | Destuffed data bit |
| rx_valid | output | 1 | `rx_bit_out` holds a data bit this cycle |
| rx_stuff_err | output | 1 | Stuff error pulse |

## Verification
The transmit path is driven with long low runs, long high runs, alternating bits, and runs that straddle an inserted bit. Together these separate a correct insert-and-restart count from one that ignores the stuff bit or miscounts by one. Runs broken by a dropped enable or a repeated start-of-frame marker show whether the counter really clears. The receive path gets a legally stuffed stream, runs of six of each polarity, and long runs outside the region. These tell removal apart from error reporting and from plain pass-through.

// File: rtl/can_stuff_pkg.sv
package can_stuff_pkg;

  localparam int DEF_RUN_LEN = 5;

  typedef enum logic [1:0] {
    RX_PASS = 2'd0,
    RX_DROP = 2'd1,
    RX_ERR  = 2'd2
  } rx_act_e;

  // Run length after accepting one bit: grows on a repeat, restarts at one otherwise.
  function automatic int unsigned bump_run(int unsigned cnt, logic same);
    return same ? cnt + 1 : 1;
  endfunction

  // True when the incoming bit extends the current run.
  function automatic logic extends_run(logic bit_in, logic last, int unsigned cnt, logic sof);
    return (bit_in == last) && (cnt != 0) && !sof;
  endfunction

endpackage

// File: rtl/can_tx_stuffer.sv
module can_tx_stuffer
  import can_stuff_pkg::*;
#(
  parameter int RUN_LEN = DEF_RUN_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic en,
  input  logic sof,
  input  logic in_bit,
  output logic ready,
  output logic out_bit
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LIMIT = CW'(RUN_LEN);
  localparam logic [CW-1:0] ONE   = CW'(1);

  logic [CW-1:0] run_cnt;
  logic [CW-1:0] run_nxt;
  logic          last_bit;
  logic          pend;

  // Named internal events
  logic stuff_slot;
  logic take;
  logic same;

  assign stuff_slot = strobe && pend;
  assign take       = strobe && !pend;
  assign same       = extends_run(in_bit, last_bit, int'(run_cnt), sof);
  assign ready      = !pend;

  always_comb run_nxt = CW'(bump_run(int'(run_cnt), same));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      last_bit <= 1'b1;
      pend     <= 1'b0;
      out_bit  <= 1'b1;
    end else if (stuff_slot) begin
      out_bit  <= ~last_bit;
      last_bit <= ~last_bit;
      run_cnt  <= ONE;
      pend     <= 1'b0;
    end else if (take) begin
      out_bit <= in_bit;
      if (en) begin
        run_cnt  <= run_nxt;
        last_bit <= in_bit;
        pend     <= (run_nxt == LIMIT);
      end else begin
        run_cnt <= '0;
      end
    end else if (!en && !pend) begin
      run_cnt <= '0;
    end
  end

  AST_STUFF_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_slot |=> (out_bit != $past(out_bit)));                      // R1
  AST_READY_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !ready) |=> ready);                                     // R2
  AST_TX_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= LIMIT);                                                 // R3
  AST_TX_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !pend) |=> (run_cnt == '0));                               // R9

endmodule

// File: rtl/can_rx_destuffer.sv
module can_rx_destuffer
  import can_stuff_pkg::*;
#(
  parameter int RUN_LEN = DEF_RUN_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic en,
  input  logic sof,
  input  logic in_bit,
  output logic out_bit,
  output logic out_valid,
  output logic stuff_err
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LIMIT = CW'(RUN_LEN);
  localparam logic [CW-1:0] ONE   = CW'(1);

  logic [CW-1:0] run_cnt;
  logic [CW-1:0] run_nxt;
  logic          last_bit;

  // Named internal events
  logic    at_limit;
  logic    same;
  rx_act_e act;

  assign at_limit = en && !sof && (run_cnt == LIMIT);
  assign same     = extends_run(in_bit, last_bit, int'(run_cnt), sof);

  always_comb run_nxt = CW'(bump_run(int'(run_cnt), same));

  always_comb begin
    if (!at_limit)               act = RX_PASS;
    else if (in_bit == last_bit) act = RX_ERR;
    else                         act = RX_DROP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt   <= '0;
      last_bit  <= 1'b1;
      out_bit   <= 1'b1;
      out_valid <= 1'b0;
      stuff_err <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      stuff_err <= 1'b0;
      if (strobe) begin
        unique case (act)
          RX_DROP: begin
            run_cnt  <= ONE;
            last_bit <= in_bit;
          end
          RX_ERR: begin
            stuff_err <= 1'b1;
            run_cnt   <= '0;
          end
          default: begin
            out_valid <= 1'b1;
            out_bit   <= in_bit;
            if (en) begin
              run_cnt  <= run_nxt;
              last_bit <= in_bit;
            end else begin
              run_cnt <= '0;
            end
          end
        endcase
      end else if (!en) begin
        run_cnt <= '0;
      end
    end
  end

  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && act == RX_DROP) |=> !out_valid);                        // R5
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(stuff_err && out_valid));                                        // R6
  AST_RX_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= LIMIT);                                                 // R7
  AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !en) |=> (out_valid && !stuff_err));                    // R8
  AST_RESULT_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || stuff_err) |-> $past(strobe));                       // R11

endmodule

// File: rtl/can_stuff_codec.sv
module can_stuff_codec
  import can_stuff_pkg::*;
#(
  parameter int RUN_LEN = DEF_RUN_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_strobe,
  input  logic tx_en,
  input  logic tx_sof,
  input  logic tx_bit_in,
  output logic tx_ready,
  output logic tx_bit_out,
  input  logic rx_strobe,
  input  logic rx_en,
  input  logic rx_sof,
  input  logic rx_bit_in,
  output logic rx_bit_out,
  output logic rx_valid,
  output logic rx_stuff_err
);

  can_tx_stuffer #(.RUN_LEN(RUN_LEN)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (tx_strobe),
    .en      (tx_en),
    .sof     (tx_sof),
    .in_bit  (tx_bit_in),
    .ready   (tx_ready),
    .out_bit (tx_bit_out)
  );

  can_rx_destuffer #(.RUN_LEN(RUN_LEN)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (rx_strobe),
    .en        (rx_en),
    .sof       (rx_sof),
    .in_bit    (rx_bit_in),
    .out_bit   (rx_bit_out),
    .out_valid (rx_valid),
    .stuff_err (rx_stuff_err)
  );

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (tx_ready && !rx_valid && !rx_stuff_err));        // R10

endmodule

// File: tb/test_can_stuff_codec.sv
module test_can_stuff_codec;
  localparam int CLK_PERIOD = 10;
  localparam int RUN = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_strobe = 1'b0, tx_en = 1'b0, tx_sof = 1'b0, tx_bit_in = 1'b0;
  logic rx_strobe = 1'b0, rx_en = 1'b0, rx_sof = 1'b0, rx_bit_in = 1'b0;
  logic tx_ready, tx_bit_out, rx_bit_out, rx_valid, rx_stuff_err;

  can_stuff_codec #(.RUN_LEN(RUN)) i_can_stuff_codec (
    .clk(clk), .rst_n(rst_n),
    .tx_strobe(tx_strobe), .tx_en(tx_en), .tx_sof(tx_sof), .tx_bit_in(tx_bit_in),
    .tx_ready(tx_ready), .tx_bit_out(tx_bit_out),
    .rx_strobe(rx_strobe), .rx_en(rx_en), .rx_sof(rx_sof), .rx_bit_in(rx_bit_in),
    .rx_bit_out(rx_bit_out), .rx_valid(rx_valid), .rx_stuff_err(rx_stuff_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  // Scoreboard queues: tx holds expected line bits, rx holds {err, valid, bit}
  logic       tx_exp_q[$];
  string      tx_tag_q[$];
  logic [2:0] rx_exp_q[$];
  string      rx_tag_q[$];

  // Reference run state, kept as plain counts
  int   tref_run = 0;
  logic tref_last = 1'b1;
  bit   tref_pend = 1'b0;
  int   rref_run = 0;
  logic rref_last = 1'b1;

  logic tx_seen = 1'b0;
  logic rx_seen = 1'b0;
  always @(posedge clk) begin
    tx_seen <= tx_strobe;
    rx_seen <= rx_strobe;
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Monitor: results are sampled one cycle after each strobe (R11)
  initial begin
    forever begin
      @(negedge clk);
      if (tx_seen) begin
        if (tx_exp_q.size() == 0) check("R11", "unexpected tx slot", 1, 0);
        else begin
          logic  e;
          string t;
          e = tx_exp_q.pop_front();
          t = tx_tag_q.pop_front();
          check(t, "tx_bit_out", int'(tx_bit_out), int'(e));
        end
      end
      if (rx_seen) begin
        if (rx_exp_q.size() == 0) check("R11", "unexpected rx slot", 1, 0);
        else begin
          logic [2:0] e;
          string      t;
          e = rx_exp_q.pop_front();
          t = rx_tag_q.pop_front();
          check(t, "rx_stuff_err", int'(rx_stuff_err), int'(e[2]));
          check(t, "rx_valid", int'(rx_valid), int'(e[1]));
          if (e[1]) check(t, "rx_bit_out", int'(rx_bit_out), int'(e[0]));
        end
      end else if (rst_n) begin
        check("R11", "rx quiet without strobe", int'(rx_valid || rx_stuff_err), 0);
      end
    end
  end

  // Transmit driver: handles the stall slot and queues the expected line bits
  task automatic send_tx(input logic b, input logic en, input logic sof, input string tag);
    @(negedge clk);
    check(tag, "tx_ready", int'(tx_ready), int'(!tref_pend));
    if (tref_pend) begin
      tx_bit_in = ~b; tx_en = en; tx_sof = 1'b0; tx_strobe = 1'b1;
      tx_exp_q.push_back(~tref_last); tx_tag_q.push_back(tag);
      tref_last = ~tref_last; tref_run = 1; tref_pend = 1'b0;
      @(negedge clk); tx_strobe = 1'b0;
      @(negedge clk);
      check("R2", "tx_ready after stuff slot", int'(tx_ready), 1);
    end
    tx_bit_in = b; tx_en = en; tx_sof = sof; tx_strobe = 1'b1;
    tx_exp_q.push_back(b); tx_tag_q.push_back(tag);
    if (!en) tref_run = 0;
    else if (sof || tref_run == 0 || b != tref_last) begin tref_run = 1; tref_last = b; end
    else tref_run++;
    if (en && tref_run == RUN) tref_pend = 1'b1;
    @(negedge clk); tx_strobe = 1'b0; tx_sof = 1'b0;
  endtask

  // Receive driver: predicts pass, drop or error from the run count
  task automatic send_rx(input logic b, input logic en, input logic sof, input string tag);
    logic [2:0] e;
    if (en && !sof && rref_run == RUN) begin
      if (b == rref_last) begin e = 3'b100; rref_run = 0; end
      else begin e = 3'b000; rref_run = 1; rref_last = b; end
    end else begin
      e = {1'b0, 1'b1, b};
      if (!en) rref_run = 0;
      else if (sof || rref_run == 0 || b != rref_last) begin rref_run = 1; rref_last = b; end
      else rref_run++;
    end
    @(negedge clk);
    rx_bit_in = b; rx_en = en; rx_sof = sof; rx_strobe = 1'b1;
    rx_exp_q.push_back(e); rx_tag_q.push_back(tag);
    @(negedge clk); rx_strobe = 1'b0; rx_sof = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 60000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL R11 watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "tx_ready", int'(tx_ready), 1);
    check("R10", "tx_bit_out", int'(tx_bit_out), 1);
    check("R10", "rx_valid", int'(rx_valid), 0);
    check("R10", "rx_stuff_err", int'(rx_stuff_err), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 / R3: low run stuffed, then stuff bit starts a high run
    send_tx(1'b0, 1'b1, 1'b1, "R1");
    for (int i = 0; i < 4; i++) send_tx(1'b0, 1'b1, 1'b0, "R1");
    for (int i = 0; i < 5; i++) send_tx(1'b1, 1'b1, 1'b0, "R3");
    for (int i = 0; i < 6; i++) send_tx(logic'(i % 2), 1'b1, 1'b0, "R2");
    // R4: long run outside the region
    for (int i = 0; i < 8; i++) send_tx(1'b1, 1'b0, 1'b0, "R4");
    // R1: high runs, repeated insertion
    send_tx(1'b1, 1'b1, 1'b1, "R1");
    for (int i = 0; i < 11; i++) send_tx(1'b1, 1'b1, 1'b0, "R1");
    send_tx(1'b0, 1'b0, 1'b0, "R2");
    // R9: enable low clears the count
    send_tx(1'b0, 1'b1, 1'b1, "R9");
    for (int i = 0; i < 3; i++) send_tx(1'b0, 1'b1, 1'b0, "R9");
    send_tx(1'b0, 1'b0, 1'b0, "R9");
    for (int i = 0; i < 4; i++) send_tx(1'b0, 1'b1, 1'b0, "R9");
    send_tx(1'b1, 1'b1, 1'b0, "R9");
    // R9: start of frame restarts the count
    send_tx(1'b1, 1'b1, 1'b1, "R9");
    for (int i = 0; i < 3; i++) send_tx(1'b1, 1'b1, 1'b0, "R9");
    send_tx(1'b1, 1'b1, 1'b1, "R9");
    for (int i = 0; i < 3; i++) send_tx(1'b1, 1'b1, 1'b0, "R9");
    send_tx(1'b0, 1'b1, 1'b0, "R9");
    send_tx(1'b1, 1'b0, 1'b0, "R4");

    // R5 / R7: legally stuffed stream
    send_rx(1'b0, 1'b1, 1'b1, "R5");
    for (int i = 0; i < 4; i++) send_rx(1'b0, 1'b1, 1'b0, "R5");
    send_rx(1'b1, 1'b1, 1'b0, "R5");
    for (int i = 0; i < 4; i++) send_rx(1'b1, 1'b1, 1'b0, "R7");
    send_rx(1'b0, 1'b1, 1'b0, "R7");
    send_rx(1'b0, 1'b1, 1'b0, "R7");
    send_rx(1'b1, 1'b1, 1'b0, "R7");
    // R6: six recessive, then restart after the error
    send_rx(1'b1, 1'b1, 1'b1, "R6");
    for (int i = 0; i < 5; i++) send_rx(1'b1, 1'b1, 1'b0, "R6");
    for (int i = 0; i < 4; i++) send_rx(1'b1, 1'b1, 1'b0, "R7");
    send_rx(1'b1, 1'b0, 1'b0, "R8");
    // R6: six dominant
    send_rx(1'b0, 1'b1, 1'b1, "R6");
    for (int i = 0; i < 5; i++) send_rx(1'b0, 1'b1, 1'b0, "R6");
    // R8: region off, no removal or error
    for (int i = 0; i < 8; i++) send_rx(1'b0, 1'b0, 1'b0, "R8");
    // R9: start of frame and enable drop both restart the count
    send_rx(1'b0, 1'b1, 1'b1, "R9");
    for (int i = 0; i < 3; i++) send_rx(1'b0, 1'b1, 1'b0, "R9");
    send_rx(1'b0, 1'b1, 1'b1, "R9");
    for (int i = 0; i < 3; i++) send_rx(1'b0, 1'b1, 1'b0, "R9");
    send_rx(1'b0, 1'b0, 1'b0, "R9");
    for (int i = 0; i < 4; i++) send_rx(1'b0, 1'b1, 1'b0, "R9");
    send_rx(1'b0, 1'b1, 1'b0, "R9");
    send_rx(1'b0, 1'b1, 1'b0, "R6");

    repeat (4) @(negedge clk);
    check("R11", "tx queue drained", tx_exp_q.size(), 0);
    check("R11", "rx queue drained", rx_exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule